// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time Counter

This block keeps a 64-bit nanosecond time of day for a precision time protocol endpoint. It runs on a reference clock that is faster than the nominal tick rate. A 32-bit fractional phase accumulator adds a programmable addend on every enabled reference cycle. Each carry out of the accumulator is one nominal tick, and on each tick the time value grows by a programmed whole number of nanoseconds. Software chooses the addend as ceil(2^32 / ratio), where the ratio is the reference frequency over the nominal frequency. Software trims the clock's frequency by nudging the addend. The fractional residue is never discarded.

A prescaler divides the nominal ticks to form an output clock. Two identical fixed-interval generators each raise a pulse that is one output-clock period wide when their programmed interval has elapsed. The interval value is held in nanoseconds with a one-period offset: software writes prescale × period × divider − period. Each generator keeps the remainder past its target, so pulses recur with no drift.

All programming is through plain write strobes. The time value can be loaded only while the block is disabled. There is no streaming data path, so every pin is plain control or status.

Top module: `tod_counter`

## Requirements
- R1: After reset the time is 0, both pulses are 0, out_clk is 0, and all programmed registers are 0, so no ticks occur.
- R2: On each cycle with enable high, the accumulator becomes (accumulator + addend) mod 2^32, and a carry out of bit 31 is one nominal tick. After a load, N enabled cycles give floor(N × addend / 2^32) ticks.
- R3: Each tick adds the programmed period (in ns) to the 64-bit time, with the carry running across all 64 bits.
- R4: An addend write is used from the following cycle on, and the accumulator's residue is kept across the write.
- R5: A time_we strobe while enable is low loads time_wdata. The same strobe clears the accumulator, the prescaler count, and each generator's elapsed count and pulse. While enable is high, time_we is ignored.
- R6: While enable is low, the time, the accumulator, the prescaler, both pulses and out_clk hold their values.
- R7: The prescaler count steps through 0 to P−1 on ticks, where P is the programmed prescale and P=0 acts as 1. out_clk is high while the count is below (P+1)/2.
- R8: A generator with interval I fires on the tick at which the nanoseconds elapsed since its last firing reach I + period. The excess over that target is kept as the start of the next interval.
- R9: A pulse rises on its firing tick and stays high for P ticks, which is one output-clock period.
- R10: There are two generators, and interval_we bit g writes only generator g. They run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; low freezes all state |
| addend_we | input | 1 | Addend write strobe |
| addend_wdata | input | 32 | Frequency compensation addend |
| period_we | input | 1 | Tick period write strobe |
| period_wdata | input | PER_W (8) | Nominal tick period in ns |
| prescale_we | input | 1 | Prescale write strobe |
| prescale_wdata | input | PRS_W (16) | Output clock divider |
| interval_we | input | N_GEN (2) | Per-generator interval write strobes |
| interval_wdata | input | IVL_W (32) | Interval value in ns (with one-period offset) |
| time_we | input | 1 | Time load strobe (honoured only while disabled) |
| time_wdata | input | TIME_W (64) | Time load value in ns |
| time_ns | output | TIME_W (64) | Current time of day in ns |
| out_clk | output | 1 | Prescaled output clock |
| pulse | output | N_GEN (2) | Interval pulses, one bit per generator |

## Verification
The assertions assume that the addend is below 2^32, which is implied by a ratio above 1.0. They also assume that software rewrites the prescale only at points where an output-clock edge may shift, and that time loads come only with enable low. The stimulus keeps to this: all programming happens in disabled windows, and the one live addend rewrite uses a value far below 2^32. The prescale never changes while the prescaler is running.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int FRAC_W = 32;
  typedef logic [FRAC_W-1:0] frac_t;
endpackage

// File: rtl/tod_phase_acc.sv
module tod_phase_acc
  import tod_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  clr,
  input  logic  add_we,
  input  frac_t add_wdata,
  output logic  tick
);
  frac_t             addend_q;
  frac_t             acc_q;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, addend_q};
    tick = en & sum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addend_q <= '0;
      acc_q    <= '0;
    end else begin
      if (add_we) addend_q <= add_wdata;
      if (clr)     acc_q <= '0;
      else if (en) acc_q <= sum[FRAC_W-1:0];
    end
  end

  AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !clr |=> $stable(acc_q)); // R6
  AST_ADDEND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    add_we |=> addend_q == $past(add_wdata)); // R4
endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int PRS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             prs_we,
  input  logic [PRS_W-1:0] prs_wdata,
  output logic             oclk,
  output logic [PRS_W-1:0] width
);
  logic [PRS_W-1:0] prs_q;
  logic [PRS_W-1:0] cnt_q;
  logic [PRS_W-1:0] lim;
  logic [PRS_W:0]   half;

  always_comb begin
    lim   = (prs_q == '0) ? '0 : prs_q - 1'b1;
    width = (prs_q == '0) ? PRS_W'(1) : prs_q;
    half  = ({1'b0, prs_q} + 1'b1) >> 1;
    oclk  = {1'b0, cnt_q} < half;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prs_q <= '0;
      cnt_q <= '0;
    end else begin
      if (prs_we) prs_q <= prs_wdata;
      if (clr)       cnt_q <= '0;
      else if (tick) cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
    end
  end

  AST_OCLK_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oclk) && !$past(prs_we) |-> cnt_q == '0); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clr |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/tod_interval_pulse.sv
module tod_interval_pulse #(
  parameter int PER_W = 8,
  parameter int IVL_W = 32,
  parameter int PRS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [PER_W-1:0] per,
  input  logic             ivl_we,
  input  logic [IVL_W-1:0] ivl_wdata,
  input  logic [PRS_W-1:0] width,
  output logic             pulse
);
  localparam int EW = IVL_W + 2;

  logic [IVL_W-1:0] ivl_q;
  logic [EW-2:0]    ela_q;
  logic [PRS_W-1:0] pcnt_q;
  logic [EW-1:0]    ela_nx;
  logic [EW-1:0]    tgt;
  logic [EW-1:0]    rem;
  logic             fire;

  always_comb begin
    ela_nx = {1'b0, ela_q} + EW'(per);
    tgt    = EW'(ivl_q) + EW'(per);
    rem    = ela_nx - tgt;
    fire   = tick && (ela_nx >= tgt);
    pulse  = pcnt_q != '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      ela_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (ivl_we) ivl_q <= ivl_wdata;
      if (clr) begin
        ela_q  <= '0;
        pcnt_q <= '0;
      end else if (tick) begin
        if (fire) begin
          ela_q  <= rem[EW-2:0];
          pcnt_q <= width;
        end else begin
          ela_q <= ela_nx[EW-2:0];
          if (pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
        end
      end
    end
  end

  AST_FIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr && (ela_nx >= tgt) |=> pulse); // R8
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clr |=> $stable(pulse)); // R6
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(tick)); // R9
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int PER_W  = 8,
  parameter int PRS_W  = 16,
  parameter int IVL_W  = 32,
  parameter int N_GEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              addend_we,
  input  logic [FRAC_W-1:0] addend_wdata,
  input  logic              period_we,
  input  logic [PER_W-1:0]  period_wdata,
  input  logic              prescale_we,
  input  logic [PRS_W-1:0]  prescale_wdata,
  input  logic [N_GEN-1:0]  interval_we,
  input  logic [IVL_W-1:0]  interval_wdata,
  input  logic              time_we,
  input  logic [TIME_W-1:0] time_wdata,
  output logic [TIME_W-1:0] time_ns,
  output logic              out_clk,
  output logic [N_GEN-1:0]  pulse
);
  logic             tick;
  logic             load;
  logic [PER_W-1:0] per_q;
  logic [PRS_W-1:0] width;

  assign load = time_we & ~enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= '0;
      time_ns <= '0;
    end else begin
      if (period_we) per_q <= period_wdata;
      if (load)      time_ns <= time_wdata;
      else if (tick) time_ns <= time_ns + TIME_W'(per_q);
    end
  end

  tod_phase_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .clr       (load),
    .add_we    (addend_we),
    .add_wdata (addend_wdata),
    .tick      (tick)
  );

  tod_prescaler #(.PRS_W(PRS_W)) u_prs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr       (load),
    .prs_we    (prescale_we),
    .prs_wdata (prescale_wdata),
    .oclk      (out_clk),
    .width     (width)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_ivl
    tod_interval_pulse #(.PER_W(PER_W), .IVL_W(IVL_W), .PRS_W(PRS_W)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .clr       (load),
      .per       (per_q),
      .ivl_we    (interval_we[g]),
      .ivl_wdata (interval_wdata),
      .width     (width),
      .pulse     (pulse[g])
    );
  end

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !time_we |=> $stable(time_ns)); // R6
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (time_ns == $past(time_ns)) ||
               (time_ns == $past(time_ns + TIME_W'(per_q)))); // R3
  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && time_we |=> time_ns == $past(time_wdata)); // R5
endmodule

// File: tb/tod_counter_bench.sv
`timescale 1ns/100ps
module tod_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        addend_we = 1'b0;
  logic [31:0] addend_wdata = '0;
  logic        period_we = 1'b0;
  logic [7:0]  period_wdata = '0;
  logic        prescale_we = 1'b0;
  logic [15:0] prescale_wdata = '0;
  logic [1:0]  interval_we = '0;
  logic [31:0] interval_wdata = '0;
  logic        time_we = 1'b0;
  logic [63:0] time_wdata = '0;
  logic [63:0] time_ns;
  logic        out_clk;
  logic [1:0]  pulse;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tod_counter u_tod_counter (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .addend_we(addend_we), .addend_wdata(addend_wdata),
    .period_we(period_we), .period_wdata(period_wdata),
    .prescale_we(prescale_we), .prescale_wdata(prescale_wdata),
    .interval_we(interval_we), .interval_wdata(interval_wdata),
    .time_we(time_we), .time_wdata(time_wdata),
    .time_ns(time_ns), .out_clk(out_clk), .pulse(pulse)
  );

  typedef struct packed {
    logic [31:0] add;
    logic [7:0]  per;
    logic [7:0]  n;
    logic [63:0] t0;
    logic [63:0] exp;
  } vec_t;

  // R2/R3: ticks = floor(n*add/2^32) after a load, time = t0 + ticks*per
  localparam vec_t VECS [6] = '{
    '{32'h8000_0000, 8'd10, 8'd10, 64'd0,           64'd50},
    '{32'h4000_0000, 8'd7,  8'd12, 64'd100,         64'd121},
    '{32'hC000_0000, 8'd10, 8'd8,  64'd0,           64'd60},
    '{32'h9999_99A4, 8'd10, 8'd5,  64'd0,           64'd30},
    '{32'h9999_9999, 8'd10, 8'd5,  64'd0,           64'd20},
    '{32'h8000_0000, 8'd3,  8'd6,  64'hFFFF_FFFC,   64'h1_0000_0005}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] add, input logic [7:0] per, input logic [63:0] t0);
    @(negedge clk);
    enable = 1'b0;
    addend_we = 1'b1; addend_wdata = add;
    period_we = 1'b1; period_wdata = per;
    time_we = 1'b1;   time_wdata = t0;
    @(negedge clk);
    addend_we = 1'b0; period_we = 1'b0; time_we = 1'b0;
  endtask

  task automatic write_ivl(input int g, input logic [31:0] v);
    @(negedge clk);
    interval_we = 2'b00; interval_we[g] = 1'b1; interval_wdata = v;
    @(negedge clk);
    interval_we = 2'b00;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", time_ns, 64'd0);
    chk("R1 pulse", {62'd0, pulse}, 64'd0);
    chk("R1 out_clk", {63'd0, out_clk}, 64'd0);
    enable = 1'b1;
    repeat (4) @(negedge clk);
    enable = 1'b0;
    chk("R1 no ticks with zero addend", time_ns, 64'd0);

    // R2 R3 R5: vector table
    foreach (VECS[i]) begin
      setup(VECS[i].add, VECS[i].per, VECS[i].t0);
      chk("R5 load", time_ns, VECS[i].t0);
      enable = 1'b1;
      repeat (int'(VECS[i].n)) @(negedge clk);
      enable = 1'b0;
      chk("R2 R3 vector", time_ns, VECS[i].exp);
    end

    // R4: addend rewrite keeps residue
    setup(32'h8000_0000, 8'd10, 64'd0);
    enable = 1'b1;
    @(negedge clk);
    addend_we = 1'b1; addend_wdata = 32'h2000_0000;
    @(negedge clk);
    addend_we = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b0;
    chk("R4 residue kept across addend write", time_ns, 64'd10);

    // R5: load ignored while enabled (addend 0 -> no ticks)
    setup(32'h0, 8'd10, 64'd10);
    enable = 1'b1;
    time_we = 1'b1; time_wdata = 64'h1234;
    @(negedge clk);
    time_we = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    chk("R5 load ignored when enabled", time_ns, 64'd10);

    // R7 R8 R9 R10: prescale 4, intervals 110 (12 ticks) and 70 (8 ticks)
    @(negedge clk);
    prescale_we = 1'b1; prescale_wdata = 16'd4;
    @(negedge clk);
    prescale_we = 1'b0;
    write_ivl(0, 32'd110);
    write_ivl(1, 32'd70);
    setup(32'h8000_0000, 8'd10, 64'd0);
    chk("R7 out_clk after load", {63'd0, out_clk}, 64'd1);
    chk("R5 pulses cleared by load", {62'd0, pulse}, 64'd0);
    enable = 1'b1;
    for (int k = 1; k <= 120; k++) begin
      @(negedge clk);
      n = k / 2;
      chk("R3 time", time_ns, 64'(10 * n));
      chk("R7 out_clk", {63'd0, out_clk}, 64'((n % 4) < 2));
      chk("R8 R9 pulse0", {63'd0, pulse[0]}, 64'(n >= 12 && (n % 12) < 4));
      chk("R10 pulse1", {63'd0, pulse[1]}, 64'(n >= 8 && (n % 8) < 4));
    end
    // R6: hold while disabled (n = 60)
    enable = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 time held", time_ns, 64'd600);
    chk("R6 pulses held", {62'd0, pulse}, 64'd1);
    chk("R6 out_clk held", {63'd0, out_clk}, 64'd1);
    enable = 1'b1;
    @(negedge clk);
    chk("R6 accumulator residue held", time_ns, 64'd600);
    @(negedge clk);
    enable = 1'b0;
    chk("R6 resumes after hold", time_ns, 64'd610);
    chk("R9 pulse0 still high at tick 61", {63'd0, pulse[0]}, 64'd1);
    // R5: load clears generators
    setup(32'h8000_0000, 8'd10, 64'd0);
    chk("R5 generator pulse cleared", {62'd0, pulse}, 64'd0);
    finish_run();
  end
endmodule